// File: doc/BRIEF.md
# Three-Phase Staggered Gate Sequencer

This block turns one externally supplied switching clock into three interleaved switching periods and drives one gate enable per channel in peak-current-mode fashion. The switching clock is brought into the fast system clock domain through a synchroniser and an edge detector. Each rising edge advances a shared phase counter that wraps every `PERIOD` counts. Channel *i* starts its period when the counter enters slot `i*PERIOD/NCH`, so with the default of twelve counts and three channels the starts fall on counts 0, 4 and 8. That is a 120° stagger, which spreads the input current ripple.

At its start slot a channel raises its gate, unless its dimming enable is low or the global fault inhibit is set. The gate then falls on the first of these events: a synchronised current-sense trip seen once a leading-edge blanking window of `BLANK_CYC` system cycles has passed, the maximum on-time of `MAX_ON` switching counts, a low dimming enable, or the fault inhibit. Once a gate has fallen it stays low until that channel's next start slot. Each channel also has a discharge strobe that is high whenever its gate is low, so that an external slope-compensation capacitor can be reset.

Top module: `tri_phase_gate_seq`

## Requirements
- R1: Each channel's gate rises exactly once per `PERIOD` (12) switching clock rising edges while enabled, so successive rises of one channel are 12 switching counts apart.
- R2: Channel i rises 4*i switching counts after channel 0 in the same period, because the start slots are counts 0, 4 and 8 of the 12-count cycle.
- R3: With no current-sense trip, a gate stays high for exactly `MAX_ON` (11) switching counts and then falls.
- R4: A trip that is present in synchronised form during the `BLANK_CYC` system cycles after a gate rises is ignored. A trip held high across a rise gives a pulse exactly `BLANK_CYC`+1 system cycles wide.
- R5: Once blanking has ended, an asserted trip lowers the gate on the third system clock edge after the raw trip input rises: two edges to synchronise it and one to register the gate.
- R6: Each discharge output is at all times the inverse of its channel's gate.
- R7: A low dimming enable lowers that channel's gate on the next system clock edge, and the gate does not rise while the enable stays low.
- R8: The fault inhibit lowers all three gates on the next system clock edge, and no gate rises while it is asserted.
- R9: A gate that has been ended by a trip, by dimming or by a fault stays low until that channel's next start slot, even if the cause goes away earlier in the period.
- R10: A trip pulse that begins and ends inside the blanking window has no effect: the pulse still runs to the full `MAX_ON` counts.
- R11: During reset all gates are low and all discharge outputs are high. The first switching edge after reset is count 0, which is channel 0's start slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock used for synchronising and blanking |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_clk_i | input | 1 | External switching clock; each rising edge is one phase count |
| cs_trip_i | input | NCH | Per-channel current-sense comparator trip, asynchronous |
| dim_en_i | input | NCH | Per-channel internal dimming enable, active high |
| fault_i | input | 1 | Global fault inhibit, active high |
| gate_o | output | NCH | Per-channel gate enable |
| dis_o | output | NCH | Per-channel slope-capacitor discharge strobe, high while the gate is low |

## Verification
If the shared phase counter is wrong, every channel shows it at once. The spacing between rises of different channels moves away from 4 counts, or the period moves away from 12 counts, and this is visible within one switching period. A blanking counter that is loaded or decremented wrongly changes the width of the pulse produced by a held trip, which is exactly `BLANK_CYC`+1 system cycles. A trip that is not discarded shows up as a short pulse where a full-width pulse is expected. A faulty on-time counter or a faulty termination latch shows up as a pulse wider than 11 counts, or as a second rise inside one period after a trip, a dimming drop or a fault has cleared.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   parameter int unsigned TPG_DEF_NCH    = 3;
   parameter int unsigned TPG_DEF_PERIOD = 12;
   parameter int unsigned TPG_DEF_MAXON  = 11;
   parameter int unsigned TPG_DEF_BLANK  = 20;

   // start slot of a channel within the phase cycle
   function automatic int unsigned slot_of(input int unsigned ch,
                                           input int unsigned period,
                                           input int unsigned nch);
      return (ch * period) / nch;
   endfunction
endpackage

// File: rtl/tpg_sync.sv
module tpg_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tpg_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tpg_phase_ctr.sv
module tpg_phase_ctr #(
   parameter int unsigned PERIOD = 12,
   localparam int unsigned CW    = $clog2(PERIOD)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
   logic [CW-1:0] cnt_q;

   // reset to the last count so the first tick lands on slot 0
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= LAST;
      else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/tpg_chan.sv
module tpg_chan #(
   parameter int unsigned MAX_ON    = 11,
   parameter int unsigned BLANK_CYC = 20,
   parameter bit          DIS_REG   = 1'b1,
   localparam int unsigned OW       = $clog2(MAX_ON + 1),
   localparam int unsigned BW       = $clog2(BLANK_CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic slot_i,
   input  logic trip_i,
   input  logic en_i,
   input  logic fault_i,
   output logic gate_o,
   output logic dis_o
);
   logic          gate_q, gate_d;
   logic [BW-1:0] blank_q, blank_d;
   logic [OW-1:0] on_q, on_d;

   always_comb begin
      gate_d  = gate_q;
      blank_d = blank_q;
      on_d    = on_q;
      if (slot_i) begin
         gate_d  = en_i && !fault_i;
         blank_d = BW'(BLANK_CYC);
         on_d    = '0;
      end else if (gate_q) begin
         if (!en_i || fault_i)                          gate_d  = 1'b0;
         else if (tick_i && on_q == OW'(MAX_ON - 1))    gate_d  = 1'b0;
         else if (blank_q != '0)                        blank_d = blank_q - BW'(1);
         else if (trip_i)                               gate_d  = 1'b0;
         if (tick_i) on_d = on_q + OW'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gate_q  <= 1'b0;
         blank_q <= '0;
         on_q    <= '0;
      end else begin
         gate_q  <= gate_d;
         blank_q <= blank_d;
         on_q    <= on_d;
      end
   end

   assign gate_o = gate_q;

   if (DIS_REG) begin : g_dis_reg
      logic dis_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) dis_q <= 1'b1;
         else         dis_q <= ~gate_d;
      end
      assign dis_o = dis_q;
   end else begin : g_dis_comb
      assign dis_o = ~gate_q;
   end
endmodule

// File: rtl/tri_phase_gate_seq.sv
module tri_phase_gate_seq #(
   parameter int unsigned NCH       = tpg_pkg::TPG_DEF_NCH,
   parameter int unsigned PERIOD    = tpg_pkg::TPG_DEF_PERIOD,
   parameter int unsigned MAX_ON    = tpg_pkg::TPG_DEF_MAXON,
   parameter int unsigned BLANK_CYC = tpg_pkg::TPG_DEF_BLANK,
   parameter int unsigned SYNC_STG  = 2,
   parameter bit          DIS_REG   = 1'b1,
   localparam int unsigned CW       = $clog2(PERIOD)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           sw_clk_i,
   input  logic [NCH-1:0] cs_trip_i,
   input  logic [NCH-1:0] dim_en_i,
   input  logic           fault_i,
   output logic [NCH-1:0] gate_o,
   output logic [NCH-1:0] dis_o
);
   if (PERIOD % NCH != 0) begin : g_bad_period
      $error("tri_phase_gate_seq: PERIOD must be a multiple of NCH");
   end
   if (MAX_ON >= PERIOD || MAX_ON < 1) begin : g_bad_maxon
      $error("tri_phase_gate_seq: MAX_ON must lie in 1..PERIOD-1");
   end
   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("tri_phase_gate_seq: BLANK_CYC must be at least 1");
   end

   logic           sw_s, sw_d_q, sw_tick;
   logic [CW-1:0]  phase_cnt, phase_nxt;
   logic [NCH-1:0] trip_s;

   tpg_sync #(.W(1), .STAGES(SYNC_STG)) u_sw_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sw_clk_i), .q_o(sw_s));

   tpg_sync #(.W(NCH), .STAGES(SYNC_STG)) u_trip_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_trip_i), .q_o(trip_s));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sw_d_q <= 1'b0;
      else         sw_d_q <= sw_s;
   end
   assign sw_tick = sw_s & ~sw_d_q;

   tpg_phase_ctr #(.PERIOD(PERIOD)) u_phase (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(sw_tick), .cnt_o(phase_cnt));

   assign phase_nxt = (phase_cnt == CW'(PERIOD - 1)) ? '0 : phase_cnt + CW'(1);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [CW-1:0] SLOT = CW'(tpg_pkg::slot_of(c, PERIOD, NCH));
      logic slot_hit;
      assign slot_hit = sw_tick && (phase_nxt == SLOT);

      tpg_chan #(.MAX_ON(MAX_ON), .BLANK_CYC(BLANK_CYC), .DIS_REG(DIS_REG)) u_chan (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .tick_i  (sw_tick),
         .slot_i  (slot_hit),
         .trip_i  (trip_s[c]),
         .en_i    (dim_en_i[c]),
         .fault_i (fault_i),
         .gate_o  (gate_o[c]),
         .dis_o   (dis_o[c]));
   end
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
   parameter int unsigned NCH    = 3,
   parameter int unsigned PERIOD = 12,
   parameter int unsigned MAX_ON = 11,
   localparam int unsigned CW    = $clog2(PERIOD),
   localparam int unsigned OW    = $clog2(MAX_ON + 1)
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           tick_i,
   input logic [CW-1:0]  cnt_i,
   input logic [NCH-1:0] en_i,
   input logic           fault_i,
   input logic [NCH-1:0] gate_i,
   input logic [NCH-1:0] dis_i
);
   p_dis_inverse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dis_i == ~gate_i);

   p_fault_kill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> (gate_i == '0));

   for (genvar c = 0; c < NCH; c++) begin : g_c
      localparam logic [CW-1:0] SLOT = CW'((c * PERIOD) / NCH);
      logic [OW-1:0] hi_ticks_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)         hi_ticks_q <= '0;
         else if (!gate_i[c]) hi_ticks_q <= '0;
         else if (tick_i)     hi_ticks_q <= hi_ticks_q + OW'(1);
      end

      p_dim_kill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !en_i[c] |=> !gate_i[c]);

      p_start_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(gate_i[c]) |-> (cnt_i == SLOT));

      p_blank_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($rose(gate_i[c]) && en_i[c] && !fault_i) |=> gate_i[c]);

      p_max_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         gate_i[c] |-> (hi_ticks_q < OW'(MAX_ON)));
   end
endmodule

bind tri_phase_gate_seq tpg_chk #(.NCH(NCH), .PERIOD(PERIOD), .MAX_ON(MAX_ON)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tick_i  (sw_tick),
   .cnt_i   (phase_cnt),
   .en_i    (dim_en_i),
   .fault_i (fault_i),
   .gate_i  (gate_o),
   .dis_i   (dis_o));

// File: tb/tri_phase_gate_seq_tb.sv
`timescale 1ns/1ps
module tri_phase_gate_seq_tb;
   localparam int NCH = 3, PERIOD = 12, MAX_ON = 11, BLANK = 20;
   localparam int HALF_SW = 16;
   localparam int TICK = 2 * HALF_SW;
   localparam int PER_CYC = PERIOD * TICK;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sw_clk = 1'b0;
   logic [NCH-1:0] trip = '0;
   logic [NCH-1:0] en = '1;
   logic           fault = 1'b0;
   logic [NCH-1:0] gate, dis;

   int tests = 0, fails = 0;
   int cyc = 0, swc = 0, dis_bad = 0;
   int rc[NCH], fc[NCH], lr[NCH], per[NCH], wid[NCH];
   logic [NCH-1:0] prev = '0;

   always #2.5 clk = ~clk;

   tri_phase_gate_seq #(.NCH(NCH), .PERIOD(PERIOD), .MAX_ON(MAX_ON), .BLANK_CYC(BLANK)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sw_clk_i(sw_clk), .cs_trip_i(trip),
      .dim_en_i(en), .fault_i(fault), .gate_o(gate), .dis_o(dis));

   initial begin
      for (int c = 0; c < NCH; c++) begin
         rc[c] = 0; fc[c] = 0; lr[c] = 0; per[c] = 0; wid[c] = 0;
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (swc == HALF_SW - 1) begin sw_clk <= ~sw_clk; swc <= 0; end
      else swc <= swc + 1;
      if (rst_n && dis !== ~gate) dis_bad++;
      for (int c = 0; c < NCH; c++) begin
         if (gate[c] && !prev[c]) begin per[c] = cyc - lr[c]; lr[c] = cyc; rc[c]++; end
         if (!gate[c] && prev[c]) begin wid[c] = cyc - lr[c]; fc[c]++; end
      end
      prev = gate;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d cycles expected<=100000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_rise(input int c);
      int n = rc[c];
      do @(posedge clk); while (rc[c] == n);
      @(negedge clk);
   endtask

   task automatic wait_fall(input int c);
      int n = fc[c];
      do @(posedge clk); while (fc[c] == n);
      @(negedge clk);
   endtask

   initial begin
      int n0, n1, tot;
      repeat (5) @(negedge clk);
      // R11: reset state
      chk("R11 gates low in reset", int'(gate), 0);
      chk("R11 discharge high in reset", int'(dis), 7);
      rst_n = 1'b1;
      // R11: first tick starts channel 0
      wait_rise(0);
      chk("R11 channel 1 idle at first start", int'(gate[1]), 0);

      repeat (3 * PER_CYC) @(negedge clk);
      wait_rise(2);
      for (int c = 0; c < NCH; c++) begin
         chk("R1 period in cycles", per[c], PER_CYC);
         chk("R3 max on-time width", wid[c], MAX_ON * TICK);
      end
      chk("R2 ch1 after ch0", lr[1] - lr[0], 4 * TICK);
      chk("R2 ch2 after ch1", lr[2] - lr[1], 4 * TICK);

      // R10: short trip inside blanking is discarded
      wait_rise(0);
      repeat (2) @(negedge clk);
      trip[0] = 1'b1;
      repeat (5) @(negedge clk);
      trip[0] = 1'b0;
      wait_fall(0);
      chk("R10 blank-window trip discarded", wid[0], MAX_ON * TICK);

      // R5 / R9: trip after blanking, then released mid-period
      wait_rise(1);
      repeat (96) @(negedge clk);
      trip[1] = 1'b1;
      wait_fall(1);
      chk("R5 trip ends gate", wid[1], 100);
      trip[1] = 1'b0;
      n1 = rc[1];
      repeat (100) @(negedge clk);
      chk("R9 no retrigger after trip", rc[1] - n1, 0);
      wait_rise(1);
      chk("R9 next start on slot", per[1], PER_CYC);

      // R4: trip held across the rise
      trip = '1;
      for (int c = 0; c < NCH; c++) begin
         wait_rise(c);
         wait_fall(c);
         chk("R4 held trip width", wid[c], BLANK + 1);
      end
      trip = '0;

      // R7: dimming drop mid-pulse, re-enable mid-period
      wait_rise(1);
      repeat (50) @(negedge clk);
      en[1] = 1'b0;
      @(negedge clk);
      chk("R7 dim drop lowers gate", int'(gate[1]), 0);
      en[1] = 1'b1;
      repeat (100) @(negedge clk);
      chk("R9 gate held low after dim drop", int'(gate[1]), 0);
      wait_rise(1);
      chk("R9 restart on own slot after dim", per[1], PER_CYC);

      // R7: dimming low for a whole period
      en[1] = 1'b0;
      n0 = rc[0]; n1 = rc[1];
      repeat (PER_CYC + 20) @(negedge clk);
      chk("R7 no rise while dimmed", rc[1] - n1, 0);
      chk("R7 other channel still runs", (rc[0] - n0) > 0 ? 1 : 0, 1);
      en[1] = 1'b1;

      // R8: fault inhibit
      wait_rise(0);
      repeat (30) @(negedge clk);
      fault = 1'b1;
      @(negedge clk);
      chk("R8 fault lowers all gates", int'(gate), 0);
      tot = rc[0] + rc[1] + rc[2];
      repeat (PER_CYC + 20) @(negedge clk);
      chk("R8 no rise during fault", rc[0] + rc[1] + rc[2] - tot, 0);
      fault = 1'b0;
      wait_rise(0);
      wait_fall(0);
      chk("R8 full pulse after fault clears", wid[0], MAX_ON * TICK);

      // R6: discharge tracks gate throughout
      chk("R6 discharge inverse of gate", dis_bad, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule